// File: doc/BRIEF.md
# Coprocessor Instruction Trap Decision Logic

This block sits in the host processor beside the instruction decoder. Each time an escape-class instruction or a wait instruction is ready to execute, the decoder presents one request. A request carries the instruction class, the task-switched and emulate bits of the machine status word, and the coprocessor's pending unmasked error line. For escape instructions that address a numeric memory operand, it also carries the operand's start offset, its span and the segment limit.

One clock after the request, the block returns exactly one answer. The answer is either a trap strobe with an 8-bit vector number or a proceed strobe. Trap sources are ranked. An unavailable coprocessor (vector 7) ranks first. A pending coprocessor error (vector 16) ranks second. A numeric operand whose first byte lies past the limit (vector 13) ranks third. A numeric operand that starts inside the segment but runs past its end (vector 9) ranks last. Descriptor fetching and the interrupt dispatch that follows a trap are outside the block.

Top module: `cop_trap_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, both `trap_valid` and `go_valid` are low.
- R2: An escape request (`req_kind` = 0) with `msw_ts` = 1 or `msw_em` = 1 yields a trap with vector 7.
- R3: A wait request (`req_kind` = 1) with `msw_ts` = 1 yields a trap with vector 7. For a wait request `msw_em` has no effect on the answer.
- R4: When R2 and R3 do not apply and `cop_err` = 1, an escape or wait request yields a trap with vector 16.
- R5: When R2 to R4 do not apply, an escape request with `opnd_en` = 1 and `opnd_off` > `seg_lim` yields a trap with vector 13.
- R6: When R2 to R5 do not apply, an escape request with `opnd_en` = 1 whose last byte (`opnd_off` + `opnd_span`) is above `seg_lim` or passes 2^AW - 1 yields a trap with vector 9.
- R7: Limit checks are not applied to wait requests or to escape requests with `opnd_en` = 0. Such requests proceed whatever the offset, span and limit are.
- R8: The answer appears exactly one cycle after `req_valid` = 1. At most one of `trap_valid` and `go_valid` is high, and neither is high in a cycle that follows no request.
- R9: A request that meets none of the trap conditions yields `go_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 1 | 0 = escape instruction, 1 = wait instruction |
| msw_ts | input | 1 | Task-switched bit of the status word |
| msw_em | input | 1 | Emulate bit of the status word |
| cop_err | input | 1 | Unmasked coprocessor error pending |
| opnd_en | input | 1 | Request carries a numeric memory operand |
| opnd_off | input | AW | Offset of the operand's first byte |
| opnd_span | input | SW | Operand length in bytes minus one |
| seg_lim | input | AW | Highest valid offset in the segment |
| trap_valid | output | 1 | Request must fault |
| trap_vec | output | 8 | Vector number of the fault |
| go_valid | output | 1 | Request may execute |

## Verification
The bench builds the block with AW = 6 and SW = 3. Every combination of start offset, span and limit can then be applied: 64 × 64 × 8 requests, all issued back to back. This covers every start-past-limit and tail-past-limit case and every wrap through the top of the 64-byte space. It also applies all 32 combinations of class, status bits, error line and operand flag against both a legal and an illegal operand, which confirms the ranking between sources.

// File: rtl/cop_trap_pkg.sv
package cop_trap_pkg;

    typedef enum logic {
        KIND_ESC  = 1'b0,
        KIND_WAIT = 1'b1
    } ins_kind_e;

    typedef enum logic [2:0] {
        VD_PROCEED = 3'd0,
        VD_NOCOP   = 3'd1,
        VD_COPERR  = 3'd2,
        VD_START   = 3'd3,
        VD_TAIL    = 3'd4
    } verdict_e;

    localparam logic [7:0] VEC_NOCOP  = 8'd7;
    localparam logic [7:0] VEC_TAIL   = 8'd9;
    localparam logic [7:0] VEC_START  = 8'd13;
    localparam logic [7:0] VEC_COPERR = 8'd16;

    typedef struct packed {
        logic       trap;
        logic       go;
        logic [7:0] vec;
    } answer_t;

    function automatic logic [7:0] vec_of(verdict_e v);
        case (v)
            VD_NOCOP:  return VEC_NOCOP;
            VD_COPERR: return VEC_COPERR;
            VD_START:  return VEC_START;
            VD_TAIL:   return VEC_TAIL;
            default:   return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/cop_avail_chk.sv
module cop_avail_chk
    import cop_trap_pkg::*;
(
    input  ins_kind_e kind,
    input  logic      ts,
    input  logic      em,
    input  logic      err,
    output logic      nocop,
    output logic      err_hit
);
    always_comb begin
        if (kind == KIND_ESC) nocop = ts | em;
        else                  nocop = ts;
        err_hit = err;
    end
endmodule

// File: rtl/cop_limit_chk.sv
module cop_limit_chk #(
    parameter int AW = 16,
    parameter int SW = 4
) (
    input  logic          en,
    input  logic [AW-1:0] off,
    input  logic [SW-1:0] span,
    input  logic [AW-1:0] lim,
    output logic          start_bad,
    output logic          tail_bad
);
    localparam int EW = AW + 1;

    logic [EW-1:0] last_byte;

    always_comb begin
        last_byte = {1'b0, off} + EW'(span);
        start_bad = en && (off > lim);
        tail_bad  = en && !(off > lim) &&
                    (last_byte[AW] || (last_byte[AW-1:0] > lim));
    end
endmodule

// File: rtl/cop_trap_arbiter.sv
module cop_trap_arbiter
    import cop_trap_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_kind,
    input  logic          msw_ts,
    input  logic          msw_em,
    input  logic          cop_err,
    input  logic          opnd_en,
    input  logic [AW-1:0] opnd_off,
    input  logic [SW-1:0] opnd_span,
    input  logic [AW-1:0] seg_lim,
    output logic          trap_valid,
    output logic [7:0]    trap_vec,
    output logic          go_valid
);
    ins_kind_e kind;
    logic      nocop, err_hit, start_bad, tail_bad, lim_en;
    verdict_e  verdict;
    answer_t   ans_q;

    assign kind   = ins_kind_e'(req_kind);
    assign lim_en = opnd_en && (kind == KIND_ESC);

    cop_avail_chk u_avail (
        .kind    (kind),
        .ts      (msw_ts),
        .em      (msw_em),
        .err     (cop_err),
        .nocop   (nocop),
        .err_hit (err_hit)
    );

    cop_limit_chk #(.AW(AW), .SW(SW)) u_limit (
        .en        (lim_en),
        .off       (opnd_off),
        .span      (opnd_span),
        .lim       (seg_lim),
        .start_bad (start_bad),
        .tail_bad  (tail_bad)
    );

    always_comb begin
        if      (nocop)     verdict = VD_NOCOP;
        else if (err_hit)   verdict = VD_COPERR;
        else if (start_bad) verdict = VD_START;
        else if (tail_bad)  verdict = VD_TAIL;
        else                verdict = VD_PROCEED;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ans_q <= '0;
        end else begin
            ans_q.trap <= req_valid && (verdict != VD_PROCEED);
            ans_q.go   <= req_valid && (verdict == VD_PROCEED);
            ans_q.vec  <= req_valid ? vec_of(verdict) : 8'd0;
        end
    end

    assign trap_valid = ans_q.trap;
    assign go_valid   = ans_q.go;
    assign trap_vec   = ans_q.vec;

    // R8
    excl_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(trap_valid && go_valid));
    // R8
    one_answer_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (trap_valid || go_valid));
    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!trap_valid && !go_valid));
    // R2
    esc_nocop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_kind && (msw_ts || msw_em))
        |=> (trap_valid && trap_vec == 8'd7));
    // R3
    wait_ts_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind && msw_ts) |=> (trap_valid && trap_vec == 8'd7));
    // R4
    coperr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cop_err && !msw_ts && (req_kind || !msw_em))
        |=> (trap_valid && trap_vec == 8'd16));
    // R7
    wait_nolimit_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind && !msw_ts && !cop_err) |=> go_valid);
endmodule

// File: tb/sim_cop_trap_arbiter.sv
module sim_cop_trap_arbiter;
    localparam int AW = 6;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_kind, msw_ts, msw_em, cop_err, opnd_en;
    logic [AW-1:0] opnd_off, seg_lim;
    logic [SW-1:0] opnd_span;
    logic          trap_valid, go_valid;
    logic [7:0]    trap_vec;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cop_trap_arbiter #(.AW(AW), .SW(SW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .msw_ts(msw_ts), .msw_em(msw_em), .cop_err(cop_err), .opnd_en(opnd_en),
        .opnd_off(opnd_off), .opnd_span(opnd_span), .seg_lim(seg_lim),
        .trap_valid(trap_valid), .trap_vec(trap_vec), .go_valid(go_valid)
    );

    // expected vector, 0 means proceed; tag names the requirement
    function automatic int expect_vec(bit k, bit ts, bit em, bit er, bit en,
                                      int off, int span, int lim, output string tag);
        if (!k && (ts || em)) begin tag = "R2"; return 7; end
        if (k && ts)          begin tag = "R3"; return 7; end
        if (er)               begin tag = "R4"; return 16; end
        if (!k && en) begin
            if (off > lim)        begin tag = "R5"; return 13; end
            if (off + span > lim) begin tag = "R6"; return 9; end
        end
        tag = (k || !en) ? "R7" : "R9";
        return 0;
    endfunction

    task automatic apply(bit k, bit ts, bit em, bit er, bit en,
                         int off, int span, int lim);
        string tag;
        int ev;
        ev = expect_vec(k, ts, em, er, en, off, span, lim, tag);
        req_valid = 1'b1; req_kind = k; msw_ts = ts; msw_em = em;
        cop_err = er; opnd_en = en;
        opnd_off = AW'(off); opnd_span = SW'(span); seg_lim = AW'(lim);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n_chk++;
        if (ev == 0) begin
            if (!(go_valid && !trap_valid)) begin
                n_bad++;
                $display("FAIL %s/R8 go=%0b trap=%0b vec=%0d expected proceed (k=%0b off=%0d span=%0d lim=%0d)",
                         tag, go_valid, trap_valid, trap_vec, k, off, span, lim);
            end
        end else if (!(trap_valid && !go_valid && trap_vec == 8'(ev))) begin
            n_bad++;
            $display("FAIL %s/R8 go=%0b trap=%0b vec=%0d expected trap vec=%0d (k=%0b ts=%0b em=%0b err=%0b off=%0d span=%0d lim=%0d)",
                     tag, go_valid, trap_valid, trap_vec, ev, k, ts, em, er, off, span, lim);
        end
    endtask

    task automatic check_idle(string tag);
        n_chk++;
        if (trap_valid || go_valid) begin
            n_bad++;
            $display("FAIL %s trap=%0b go=%0b expected 0 0", tag, trap_valid, go_valid);
        end
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b1; req_kind = 1'b0; msw_ts = 1'b0; msw_em = 1'b0;
        cop_err = 1'b0; opnd_en = 1'b0; opnd_off = '0; opnd_span = '0; seg_lim = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1");
        req_valid = 1'b0;
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check_idle("R1");

        // control sweep against a legal and an illegal operand
        for (int c = 0; c < 32; c++) begin
            apply(c[0], c[1], c[2], c[3], c[4], 10, 3, 40);
            apply(c[0], c[1], c[2], c[3], c[4], 50, 3, 40);
            apply(c[0], c[1], c[2], c[3], c[4], 38, 7, 40);
        end

        @(posedge clk); @(negedge clk);
        check_idle("R8");

        // exhaustive limit sweep for a clean escape with operand
        for (int lim = 0; lim < 64; lim++)
            for (int off = 0; off < 64; off++)
                for (int sp = 0; sp < 8; sp++)
                    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, off, sp, lim);

        // wait and operand-less escape ignore limits
        for (int off = 0; off < 64; off += 9) begin
            apply(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, off, 7, 0);
            apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, off, 7, 0);
        end

        @(posedge clk); @(negedge clk);
        check_idle("R8");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule